// File: doc/BRIEF.md
# Crystal-Clocked Watchdog with Early Warning

This block is a fixed-length watchdog that counts ticks of the 32768 Hz real-time-clock crystal. Firmware keeps it quiet by writing a one to a restart bit on the fast bus clock. That write crosses into the crystal domain and clears the count. If the count reaches its terminal value, the block raises a chip reset. This reset has the same effect as the external reset pin. The block holds it for a fixed recovery interval. When the reset falls, the processor starts fetching from address zero.

An overflow sets a sticky status flag in the always-on domain. The flag lives through the reset that the watchdog itself causes. Only an explicit clear write or the external reset pin removes it. When firmware has enabled it, a single one-tick interrupt pulse fires a short, fixed time before expiry. This gives firmware a chance to log its state. No firmware-visible state can turn the watchdog off. Only a hardware strap, a debug-enable input or a low wake signal keep the count at zero.

The defaults give a 1.5 s timeout (49152 ticks), a warning about 1 ms ahead (33 ticks) and a hold of about 125 ms (4100 ticks). All three are parameters.

Top module: `xtal_watchdog`

## Requirements
- R1: While and just after the external reset pin is low, chip_rst, warn_irq and ovf_flag are all 0, and the count starts from zero.
- R2: With no restart and no disable, chip_rst rises exactly TIMEOUT crystal ticks after the count last started from zero.
- R3: A bus write with kick_wr=1 and kick_data=1 clears the count within 4 crystal ticks. A write with kick_data=0 has no effect on the count.
- R4: chip_rst stays high for exactly HOLD crystal ticks and then falls (processor restart at address zero). The count restarts from zero, so the next expiry comes TIMEOUT ticks after the fall.
- R5: Restart writes made while chip_rst is high are ignored. They shorten neither the hold nor the following timeout period.
- R6: ovf_flag is set in the same tick that chip_rst rises. It stays set through the watchdog reset. A flag_clr_wr pulse clears it within 4 crystal ticks, and a low external reset pin clears it.
- R7: While strap_dis=1, or independently while dbg_en=1, the count is held at zero and no reset is raised. After the input is released, expiry comes exactly TIMEOUT ticks later.
- R8: While wake=0 the count is held at zero. After wake returns to 1, expiry comes exactly TIMEOUT ticks later.
- R9: With warn_en=1, warn_irq is a pulse one crystal tick wide that rises exactly WARN ticks before chip_rst rises. With warn_en=0 no pulse occurs.
- R10: At most one warn_irq pulse occurs per timeout period. The warning re-arms after every restart, disable or watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus clock on which firmware writes arrive |
| clk_xtal | input | 1 | 32768 Hz crystal clock, the time base |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to both domains |
| kick_wr | input | 1 | One-cycle write strobe to the restart bit (bus domain) |
| kick_data | input | 1 | Value written with kick_wr; only a one restarts |
| flag_clr_wr | input | 1 | One-cycle strobe that clears the overflow flag (bus domain) |
| warn_en | input | 1 | Enables the early-warning interrupt |
| strap_dis | input | 1 | Hardware strap; 1 disables the watchdog |
| dbg_en | input | 1 | Debug enable; 1 disables the watchdog |
| wake | input | 1 | Internal wake signal; 0 holds the count at zero |
| chip_rst | output | 1 | Chip reset request, active high, held for the recovery interval |
| warn_irq | output | 1 | Early-warning interrupt pulse, one crystal tick wide |
| ovf_flag | output | 1 | Sticky overflow status (always-on domain) |

## Verification
The checks assume several things about the inputs. warn_en, strap_dis, dbg_en and wake are treated as levels that are already settled in the crystal domain. The strobes kick_wr and flag_clr_wr are single bus-clock pulses spaced more than four crystal ticks apart, so the toggle crossing never folds two writes into one. The bench changes every level input only on a falling edge of the crystal clock. It issues each strobe as one bus cycle and then waits whole crystal ticks before the next write. Exact tick counts are therefore measured only from points free of crossing latency: reset release, the release of a disable, or the fall of chip_rst. Timing through the crossing is checked against a bounded window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } wdt_state_e;
endpackage

// File: rtl/wdt_pulse_sync.sv
module wdt_pulse_sync (
    input  logic clk_src,
    input  logic clk_dst,
    input  logic rst_n,
    input  logic src_pulse,
    output logic dst_pulse
);
    logic       tog_d, tog_q;
    logic [2:0] pipe_d, pipe_q;

    always_comb begin
        tog_d  = tog_q ^ src_pulse;
        pipe_d = {pipe_q[1:0], tog_q};
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    always_ff @(posedge clk_dst or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dst_pulse = pipe_q[2] ^ pipe_q[1];
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int TIMEOUT = 49152,
    parameter int WARN    = 33,
    parameter int HOLD    = 4100
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         kick_evt,
    input  logic                         clr_evt,
    input  logic                         disable_i,
    input  logic                         warn_en,
    output logic                         chip_rst,
    output logic                         warn_irq,
    output logic                         ovf_flag,
    output logic [$clog2(TIMEOUT+1)-1:0] count_o
);
    localparam int CW      = $clog2(TIMEOUT + 1);
    localparam int HW      = $clog2(HOLD + 1);
    localparam int WARN_AT = TIMEOUT - 1 - WARN;

    typedef struct packed {
        wdt_state_e    st;
        logic [CW-1:0] cnt;
        logic [HW-1:0] hold;
        logic          warned;
        logic          irq;
        logic          ovf;
    } core_t;

    core_t d, q;
    logic  expire;

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        expire = 1'b0;
        case (q.st)
            ST_RUN: begin
                if (disable_i || kick_evt) begin
                    d.cnt    = '0;
                    d.warned = 1'b0;
                end else if (q.cnt == CW'(TIMEOUT - 1)) begin
                    expire   = 1'b1;
                    d.st     = ST_HOLD;
                    d.cnt    = '0;
                    d.hold   = '0;
                    d.warned = 1'b0;
                    d.ovf    = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CW'(WARN_AT) && warn_en && !q.warned) begin
                        d.irq    = 1'b1;
                        d.warned = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (q.hold == HW'(HOLD - 1)) begin
                    d.st   = ST_RUN;
                    d.hold = '0;
                end else begin
                    d.hold = q.hold + 1'b1;
                end
            end
            default: d = q;
        endcase
        if (clr_evt && !expire) d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_RUN, default: '0};
        else        q <= d;
    end

    assign chip_rst = (q.st == ST_HOLD);
    assign warn_irq = q.irq;
    assign ovf_flag = q.ovf;
    assign count_o  = q.cnt;
endmodule

// File: rtl/xtal_watchdog.sv
module xtal_watchdog #(
    parameter int TIMEOUT = 49152,
    parameter int WARN    = 33,
    parameter int HOLD    = 4100
) (
    input  logic clk_bus,
    input  logic clk_xtal,
    input  logic ext_rst_n,
    input  logic kick_wr,
    input  logic kick_data,
    input  logic flag_clr_wr,
    input  logic warn_en,
    input  logic strap_dis,
    input  logic dbg_en,
    input  logic wake,
    output logic chip_rst,
    output logic warn_irq,
    output logic ovf_flag
);
    localparam int NCH = 2;
    localparam int CW  = $clog2(TIMEOUT + 1);

    logic [NCH-1:0] req;
    logic [NCH-1:0] evt;
    logic           wdt_off;
    logic [CW-1:0]  cnt_w;

    // channel 0: restart, channel 1: flag clear
    assign req     = {flag_clr_wr, kick_wr & kick_data};
    assign wdt_off = strap_dis | dbg_en | ~wake;

    for (genvar i = 0; i < NCH; i++) begin : g_sync
        wdt_pulse_sync u_sync (
            .clk_src  (clk_bus),
            .clk_dst  (clk_xtal),
            .rst_n    (ext_rst_n),
            .src_pulse(req[i]),
            .dst_pulse(evt[i])
        );
    end

    wdt_core #(
        .TIMEOUT(TIMEOUT),
        .WARN   (WARN),
        .HOLD   (HOLD)
    ) u_core (
        .clk      (clk_xtal),
        .rst_n    (ext_rst_n),
        .kick_evt (evt[0]),
        .clr_evt  (evt[1]),
        .disable_i(wdt_off),
        .warn_en  (warn_en),
        .chip_rst (chip_rst),
        .warn_irq (warn_irq),
        .ovf_flag (ovf_flag),
        .count_o  (cnt_w)
    );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
    parameter int TIMEOUT = 49152,
    parameter int WARN    = 33,
    parameter int HOLD    = 4100
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         chip_rst,
    input logic                         warn_irq,
    input logic                         ovf_flag,
    input logic                         warn_en,
    input logic                         disable_i,
    input logic                         kick_evt,
    input logic                         clr_evt,
    input logic [$clog2(TIMEOUT+1)-1:0] cnt
);
    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_len <= 0;
        else if (chip_rst) run_len <= run_len + 1;
        else               run_len <= 0;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < TIMEOUT);

    // R3
    kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_evt && !chip_rst) |=> (cnt == '0));

    // R4
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_rst) |-> (run_len == HOLD));

    // R6
    ovf_on_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst) |-> ovf_flag);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_flag) && !$past(clr_evt)) |-> ovf_flag);

    // R7
    off_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_i && !chip_rst) |=> (cnt == '0 && !chip_rst));

    // R9
    irq_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |=> !warn_irq);

    // R9
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_irq) |-> $past(warn_en));

    // R10
    irq_not_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> !chip_rst);
endmodule

bind xtal_watchdog wdt_chk #(
    .TIMEOUT(TIMEOUT),
    .WARN   (WARN),
    .HOLD   (HOLD)
) u_chk (
    .clk      (clk_xtal),
    .rst_n    (ext_rst_n),
    .chip_rst (chip_rst),
    .warn_irq (warn_irq),
    .ovf_flag (ovf_flag),
    .warn_en  (warn_en),
    .disable_i(wdt_off),
    .kick_evt (evt[0]),
    .clr_evt  (evt[1]),
    .cnt      (cnt_w)
);

// File: tb/xtal_watchdog_bench.sv
`timescale 1ns/1ps
module xtal_watchdog_bench;
    localparam int TO = 40;
    localparam int WN = 5;
    localparam int HD = 12;
    localparam int NV = 6;

    // vector table: gap ticks after a write, value written, warn enable,
    // expected reset rises and warning pulses inside the gap
    localparam int VGAP [NV] = '{25, 30, 25, 25, 30, 30};
    localparam int VKV  [NV] = '{1,  1,  0,  1,  1,  0};
    localparam int VWEN [NV] = '{1,  1,  1,  1,  1,  0};
    localparam int VRST [NV] = '{0,  0,  1,  0,  0,  1};
    localparam int VIRQ [NV] = '{0,  0,  1,  0,  0,  0};

    logic clk_bus = 1'b0, clk_xtal = 1'b0;
    logic ext_rst_n = 1'b0;
    logic kick_wr = 1'b0, kick_data = 1'b0, flag_clr_wr = 1'b0;
    logic warn_en = 1'b1, strap_dis = 1'b0, dbg_en = 1'b0, wake = 1'b1;
    logic chip_rst, warn_irq, ovf_flag;

    int checks = 0, failures = 0;
    int rst_rises = 0, irq_rises = 0;

    always #5  clk_bus  = ~clk_bus;
    always #25 clk_xtal = ~clk_xtal;

    xtal_watchdog #(.TIMEOUT(TO), .WARN(WN), .HOLD(HD)) u_xtal_watchdog (
        .clk_bus(clk_bus), .clk_xtal(clk_xtal), .ext_rst_n(ext_rst_n),
        .kick_wr(kick_wr), .kick_data(kick_data), .flag_clr_wr(flag_clr_wr),
        .warn_en(warn_en), .strap_dis(strap_dis), .dbg_en(dbg_en), .wake(wake),
        .chip_rst(chip_rst), .warn_irq(warn_irq), .ovf_flag(ovf_flag)
    );

    always @(posedge chip_rst) rst_rises++;
    always @(posedge warn_irq) irq_rises++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk_xtal);
    endtask

    task automatic do_reset();
        @(negedge clk_xtal);
        ext_rst_n = 1'b0;
        ticks(3);
        ext_rst_n = 1'b1;
    endtask

    task automatic kick(input logic v);
        @(negedge clk_bus);
        kick_wr = 1'b1; kick_data = v;
        @(negedge clk_bus);
        kick_wr = 1'b0; kick_data = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk_bus);
        flag_clr_wr = 1'b1;
        @(negedge clk_bus);
        flag_clr_wr = 1'b0;
    endtask

    // call at a crystal falling edge where the count is zero
    task automatic until_rst(output int n, output int irq_at, output int irq_hi);
        n = 0; irq_at = -1; irq_hi = 0;
        while (!chip_rst && n < 4 * TO) begin
            @(negedge clk_xtal);
            n++;
            if (warn_irq) begin
                irq_hi++;
                irq_at = n;
            end
        end
    endtask

    task automatic hold_len(input bit kick_mid, output int n);
        n = 0;
        while (chip_rst && n < 4 * HD) begin
            n++;
            if (kick_mid && n == 2) kick(1'b1);
            @(negedge clk_xtal);
        end
    endtask

    initial begin
        #1ms;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n, at, hi, r0, i0;

        // R1 reset state
        ticks(2);
        chk("R1 chip_rst in reset", chip_rst, 0);
        chk("R1 warn_irq in reset", warn_irq, 0);
        chk("R1 ovf_flag in reset", ovf_flag, 0);
        ext_rst_n = 1'b1;
        ticks(1);

        // vector table walk (R3 restart / ignored zero write, R9 enable)
        for (int v = 0; v < NV; v++) begin
            warn_en = VWEN[v][0];
            kick(VKV[v][0]);
            r0 = rst_rises; i0 = irq_rises;
            ticks(VGAP[v]);
            chk($sformatf("R3 vector %0d reset rises", v), rst_rises - r0, VRST[v]);
            chk($sformatf("R9 vector %0d warning pulses", v), irq_rises - i0, VIRQ[v]);
        end
        chk("R6 flag set after vector overflows", ovf_flag, 1);
        warn_en = 1'b1;

        // R2 exact timeout from reset, R9 warning position, R10 single pulse
        do_reset();
        chk("R1 flag cleared by pin", ovf_flag, 0);
        until_rst(n, at, hi);
        chk("R2 ticks to expiry", n, TO);
        chk("R9 warning lead", n - at, WN);
        chk("R10 warning ticks high", hi, 1);
        chk("R6 flag set at expiry", ovf_flag, 1);

        // R4 hold length and restart from zero
        hold_len(1'b0, n);
        chk("R4 hold ticks", n, HD);
        chk("R6 flag survives watchdog reset", ovf_flag, 1);
        until_rst(n, at, hi);
        chk("R4 period after release", n, TO);
        chk("R10 warning re-armed", hi, 1);

        // R5 restart write in hold ignored
        hold_len(1'b1, n);
        chk("R5 hold ticks with write", n, HD);
        until_rst(n, at, hi);
        chk("R5 period after ignored write", n, TO);

        // R6 clear write
        hold_len(1'b0, n);
        clear_flag();
        ticks(5);
        chk("R6 flag cleared by write", ovf_flag, 0);

        // R3 restart latency window
        ticks(10);
        kick(1'b1);
        @(negedge clk_xtal);
        until_rst(n, at, hi);
        n = n + 1;
        chk("R3 expiry after write in window", int'(n >= TO && n <= TO + 4), 1);
        chk("R6 flag set again", ovf_flag, 1);
        do_reset();
        chk("R6 flag cleared by pin after overflow", ovf_flag, 0);

        // R7 strap disable
        ticks(20);
        strap_dis = 1'b1;
        r0 = rst_rises;
        ticks(3 * TO);
        chk("R7 no reset while strapped", rst_rises - r0, 0);
        strap_dis = 1'b0;
        until_rst(n, at, hi);
        chk("R7 timeout after strap release", n, TO);

        // R7 debug enable
        do_reset();
        ticks(20);
        dbg_en = 1'b1;
        r0 = rst_rises;
        ticks(3 * TO);
        chk("R7 no reset under debug", rst_rises - r0, 0);
        dbg_en = 1'b0;
        until_rst(n, at, hi);
        chk("R7 timeout after debug release", n, TO);

        // R8 wake low, R9 no warning when disabled
        do_reset();
        warn_en = 1'b0;
        ticks(20);
        wake = 1'b0;
        r0 = rst_rises;
        ticks(3 * TO);
        chk("R8 no reset while asleep", rst_rises - r0, 0);
        wake = 1'b1;
        i0 = irq_rises;
        until_rst(n, at, hi);
        chk("R8 timeout after wake", n, TO);
        chk("R9 no warning when disabled", irq_rises - i0, 0);

        summary();
    end
endmodule